// File: doc/BRIEF.md
# Power-Up Configuration Load Sequencer

This block brings a configurable signal-conditioning device out of power-up. While the supply-valid input is low, the block holds every one of its registers at its power-on value. That includes a small working register file that holds the device configuration. When the supply becomes valid, the block either waits a fixed number of millisecond ticks with the analog output disabled, or skips that wait when the instant-on flag is set. It then reads one bank of one-time-programmable memory through a read port with a latency of one cycle. The bank it reads is the one the bank pointer input names, which is the most recently written one. The words go into a shadow buffer while an 8-bit checksum accumulates.

The bank is accepted only when the 8-bit two's-complement sum of all its words is zero. In that case the shadow buffer is copied into the working register file, one write strobe per word, and only then is the output enabled. If the sum is not zero, the working registers keep their defaults and the output stays disabled. In both cases the block raises its done flag, and a failed load also raises the checksum-fail flag. Once loading is finished, serial command writes may overwrite the working registers, unless the serial-disable flag is set.

States: `ST_IDLE` (first cycle after the supply becomes valid), `ST_WAIT` (counting ticks), `ST_READ` (one memory read per cycle), `ST_DRAIN` (the last word returns), `ST_CHECK` (checksum decision), `ST_COPY` (shadow to register file), `ST_RUN` (output enabled) and `ST_FAIL` (output held off). The transitions are:
- IDLE→READ when instant-on is set, and IDLE→WAIT otherwise.
- WAIT→READ on the DELAY_MS-th tick.
- READ→DRAIN after the last address is issued.
- DRAIN→CHECK.
- CHECK→COPY when the sum is zero, and CHECK→FAIL otherwise.
- COPY→RUN after the last word is written.
- RUN and FAIL hold until the supply drops. A supply drop from any state returns the block to IDLE.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `supply_ok` is 0, `out_en`, `load_done`, `csum_fail` and `mem_rd_en` are 0, and every working register reads 0x5A (`RST_VAL`).
- R2: With `instant_on`=0, no memory read is issued until DELAY_MS (25) `ms_tick` pulses have been seen after the supply became valid. Reads start in the cycle after the 25th tick.
- R3: With `instant_on`=1, the first read is issued in the first cycle after the first clock edge at which `supply_ok` is 1, and no tick is needed.
- R4: The block reads exactly WORDS (8) words, at addresses `bank_sel*WORDS + 0 .. WORDS-1`, in ascending order, one per cycle.
- R5: A bank passes when the 8-bit sum of its words, modulo 256, is 0. An all-zero bank passes, and a bank whose sum is any non-zero value fails.
- R6: On a pass, working register i holds word i of the bank, then `out_en`=1, `load_done`=1 and `csum_fail`=0. `out_en` is never 1 before the last copy write.
- R7: On a fail, the working registers keep 0x5A, `out_en`=0, `load_done`=1 and `csum_fail`=1.
- R8: A serial write (`ser_we`, `ser_addr`, `ser_wdata`) updates working register `ser_addr` only when `load_done`=1 and `wire_dis`=0. It has no effect while loading or when `wire_dis`=1.
- R9: A supply drop after start-up restores the R1 state, and the next rise reruns the whole sequence.
- R10: `ram_we` pulses exactly once per copied word on a pass, not at all on a fail, and once per accepted serial write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Supply valid; low acts as an asynchronous reset of all state |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| instant_on | input | 1 | 1 skips the power-up wait |
| wire_dis | input | 1 | 1 blocks serial writes |
| bank_sel | input | BW (2) | Index of the most recently written bank |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW (5) | Memory word address |
| mem_rdata | input | DW (8) | Read data, valid one cycle after the request |
| ser_we | input | 1 | Serial write strobe |
| ser_addr | input | WA (3) | Serial write register index |
| ser_wdata | input | DW (8) | Serial write data |
| cfg_raddr | input | WA (3) | Working register read index |
| cfg_rdata | output | DW (8) | Working register read data (combinational) |
| ram_we | output | 1 | Working register write strobe |
| out_en | output | 1 | Analog output enable |
| load_done | output | 1 | Start-up sequence finished |
| csum_fail | output | 1 | Bank checksum was non-zero |

## Verification
The assertions assume three things about the inputs: `bank_sel` stays stable from the supply rise until `load_done`, `ms_tick` is a single-cycle pulse, and memory data arrives exactly one cycle after each request. The bench sets the bank pointer and the instant-on flag while the supply is low and leaves them unchanged during loading. It pulses ticks for one cycle with idle gaps between them, and it models the memory as a register clocked on the read request. Random banks are built as random words plus a closing word that forces the sum to zero, or to a non-zero value.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_DRAIN,
        ST_CHECK,
        ST_COPY,
        ST_RUN,
        ST_FAIL
    } seq_state_t;
endpackage

// File: rtl/pwr_delay_timer.sv
module pwr_delay_timer #(
    parameter int DELAY_MS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(DELAY_MS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (en && tick)
            cnt <= cnt + 1'b1;
    end

    assign expire = en && tick && (cnt == CW'(DELAY_MS - 1));
endmodule

// File: rtl/shadow_csum.sv
module shadow_csum #(
    parameter int DW    = 8,
    parameter int WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_vld,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic                     csum_ok
);
    localparam int WA = $clog2(WORDS);

    logic [DW-1:0] stage_q [WORDS];
    logic [WA:0]   fill;
    logic [7:0]    sum;
    logic          full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) stage_q[i] <= '0;
            fill <= '0;
            sum  <= '0;
        end else if (wr_vld) begin
            stage_q[fill[WA-1:0]] <= wr_data;
            fill <= fill + 1'b1;
            sum  <= sum + wr_data[7:0];
        end
    end

    assign full    = (fill == (WA+1)'(WORDS));
    assign rd_data = stage_q[rd_idx];
    assign csum_ok = full && (sum == 8'h00);

    // R4
    shadow_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> !full);
endmodule

// File: rtl/work_regfile.sv
module work_regfile #(
    parameter int          DW      = 8,
    parameter int          WORDS   = 8,
    parameter logic [DW-1:0] RST_VAL = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] regs [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) regs[i] <= RST_VAL;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
    import cfg_boot_pkg::*;
#(
    parameter int            DW       = 8,
    parameter int            WORDS    = 8,
    parameter int            NBANKS   = 4,
    parameter int            DELAY_MS = 25,
    parameter logic [DW-1:0] RST_VAL  = 8'h5A,
    localparam int           WA       = $clog2(WORDS),
    localparam int           BW       = $clog2(NBANKS),
    localparam int           AW       = $clog2(NBANKS * WORDS)
) (
    input  logic          clk,
    input  logic          supply_ok,
    input  logic          ms_tick,
    input  logic          instant_on,
    input  logic          wire_dis,
    input  logic [BW-1:0] bank_sel,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ser_we,
    input  logic [WA-1:0] ser_addr,
    input  logic [DW-1:0] ser_wdata,
    input  logic [WA-1:0] cfg_raddr,
    output logic [DW-1:0] cfg_rdata,
    output logic          ram_we,
    output logic          out_en,
    output logic          load_done,
    output logic          csum_fail
);
    seq_state_t    state, nxt;
    logic [WA-1:0] ptr;
    logic [BW-1:0] bank_q;
    logic          rd_vld;
    logic          last;
    logic          tmr_expire;
    logic          csum_ok;
    logic [DW-1:0] shadow_word;
    logic          copy_we;
    logic          ser_ok;
    logic [WA-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;

    assign last = (ptr == WA'(WORDS - 1));

    // state register
    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = instant_on ? ST_READ : ST_WAIT;
            ST_WAIT:  if (tmr_expire) nxt = ST_READ;
            ST_READ:  if (last) nxt = ST_DRAIN;
            ST_DRAIN: nxt = ST_CHECK;
            ST_CHECK: nxt = csum_ok ? ST_COPY : ST_FAIL;
            ST_COPY:  if (last) nxt = ST_RUN;
            ST_RUN:   nxt = ST_RUN;
            ST_FAIL:  nxt = ST_FAIL;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            ptr    <= '0;
            bank_q <= '0;
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= (state == ST_READ);
            if (state == ST_IDLE)
                bank_q <= bank_sel;
            if (state == ST_READ || state == ST_COPY)
                ptr <= last ? '0 : ptr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = (state == ST_READ);
        mem_addr  = AW'(bank_q) * AW'(WORDS) + AW'(ptr);
        out_en    = (state == ST_RUN);
        load_done = (state == ST_RUN) || (state == ST_FAIL);
        csum_fail = (state == ST_FAIL);
        copy_we   = (state == ST_COPY);
        ser_ok    = ser_we && !wire_dis && load_done;
        ram_we    = copy_we || ser_ok;
        rf_waddr  = copy_we ? ptr : ser_addr;
        rf_wdata  = copy_we ? shadow_word : ser_wdata;
    end

    pwr_delay_timer #(.DELAY_MS(DELAY_MS)) u_tmr (
        .clk    (clk),
        .rst_n  (supply_ok),
        .en     (state == ST_WAIT),
        .tick   (ms_tick),
        .expire (tmr_expire)
    );

    shadow_csum #(.DW(DW), .WORDS(WORDS)) u_shadow (
        .clk     (clk),
        .rst_n   (supply_ok),
        .wr_vld  (rd_vld),
        .wr_data (mem_rdata),
        .rd_idx  (ptr),
        .rd_data (shadow_word),
        .csum_ok (csum_ok)
    );

    work_regfile #(.DW(DW), .WORDS(WORDS), .RST_VAL(RST_VAL)) u_rf (
        .clk   (clk),
        .rst_n (supply_ok),
        .we    (ram_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (cfg_raddr),
        .rdata (cfg_rdata)
    );

    // R4
    rd_seq_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R2
    rd_after_delay_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(mem_rd_en) |-> (($past(instant_on) && $past(state) == ST_IDLE) || $past(tmr_expire)));

    // R6
    en_after_copy_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(out_en) |-> ($past(ram_we) && !csum_fail));

    // R7
    fail_flag_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        $rose(load_done) |-> (csum_fail != $past(csum_ok)));
endmodule

// File: tb/sim_cfg_boot_seq.sv
`timescale 1ns/1ps
module sim_cfg_boot_seq;
    localparam int DW = 8, WORDS = 8, NBANKS = 4, DELAY_MS = 25;
    localparam int WA = 3, BW = 2, AW = 5;
    localparam logic [7:0] RSTV = 8'h5A;

    logic          clk = 1'b0;
    logic          supply_ok = 1'b0;
    logic          ms_tick = 1'b0;
    logic          instant_on = 1'b0;
    logic          wire_dis = 1'b0;
    logic [BW-1:0] bank_sel = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          ser_we = 1'b0;
    logic [WA-1:0] ser_addr = '0;
    logic [DW-1:0] ser_wdata = '0;
    logic [WA-1:0] cfg_raddr = '0;
    logic [DW-1:0] cfg_rdata;
    logic          ram_we, out_en, load_done, csum_fail;

    int total = 0, bad = 0;
    logic [7:0] mem [NBANKS*WORDS];
    logic [7:0] exp_cfg [WORDS];
    logic [AW-1:0] rec [256];
    int rd_count = 0, we_count = 0, early_cnt = 0;

    cfg_boot_seq u0 (
        .clk(clk), .supply_ok(supply_ok), .ms_tick(ms_tick), .instant_on(instant_on),
        .wire_dis(wire_dis), .bank_sel(bank_sel), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .ser_we(ser_we), .ser_addr(ser_addr), .ser_wdata(ser_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .ram_we(ram_we), .out_en(out_en),
        .load_done(load_done), .csum_fail(csum_fail)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rec[rd_count % 256] <= mem_addr;
            rd_count <= rd_count + 1;
        end
        if (ram_we) we_count <= we_count + 1;
        if (out_en && !load_done) early_cnt <= early_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bank_sum(input int b);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < WORDS; i++) s = s + mem[b*WORDS + i];
        return s;
    endfunction

    task automatic fill_bank(input int b, input bit valid);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < WORDS-1; i++) begin
            mem[b*WORDS + i] = 8'($urandom);
            s = s + mem[b*WORDS + i];
        end
        mem[b*WORDS + WORDS-1] = (8'h00 - s) + (valid ? 8'h00 : 8'(1 + $urandom_range(0, 254)));
    endtask

    task automatic cfg_all_match(input string req);
        int miss = 0;
        int first_act = 0, first_exp = 0;
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            cfg_raddr = WA'(i);
            #1;
            if (cfg_rdata !== exp_cfg[i] && miss == 0) begin
                first_act = int'(cfg_rdata);
                first_exp = int'(exp_cfg[i]);
            end
            if (cfg_rdata !== exp_cfg[i]) miss++;
        end
        chk(miss == 0, req, first_act, first_exp);
    endtask

    task automatic drop_supply();
        @(negedge clk);
        supply_ok = 1'b0;
        ms_tick = 1'b0;
        for (int i = 0; i < WORDS; i++) exp_cfg[i] = RSTV;
        #1;
        chk(!out_en && !load_done && !csum_fail && !mem_rd_en, "R1 R9 flags low in reset",
            {out_en, load_done, csum_fail, mem_rd_en}, 0);
        cfg_all_match("R1 R9 defaults");
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ser_write(input int a, input logic [7:0] d);
        @(negedge clk);
        ser_we = 1'b1;
        ser_addr = WA'(a);
        ser_wdata = d;
        @(negedge clk);
        ser_we = 1'b0;
    endtask

    task automatic boot(input int b, input bit inst, input bit ser_during_load);
        int rd_base, we_base, early_base, waited;
        bit pass;
        drop_supply();
        bank_sel = BW'(b);
        instant_on = inst;
        pass = (bank_sum(b) == 8'h00);
        rd_base = rd_count;
        we_base = we_count;
        early_base = early_cnt;
        @(negedge clk);
        supply_ok = 1'b1;
        if (inst) begin
            @(posedge clk);
            #1;
            chk(mem_rd_en && mem_addr == AW'(b*WORDS), "R3 immediate read", {mem_rd_en, mem_addr}, {1'b1, AW'(b*WORDS)});
            if (ser_during_load) begin
                @(negedge clk);
                ser_we = 1'b1;
                ser_addr = '0;
                ser_wdata = 8'hEE;
                @(negedge clk);
                ser_we = 1'b0;
            end
        end else begin
            for (int k = 0; k < DELAY_MS-1; k++) pulse_tick();
            repeat (4) @(negedge clk);
            chk(rd_count == rd_base, "R2 no read before delay", rd_count - rd_base, 0);
            pulse_tick();
        end
        waited = 0;
        while (!load_done && waited < 1000) begin
            @(negedge clk);
            waited++;
        end
        chk(load_done === 1'b1, "R6 R7 load_done set", load_done, 1);
        chk(rd_count - rd_base == WORDS, "R4 read count", rd_count - rd_base, WORDS);
        for (int i = 0; i < WORDS; i++)
            chk(rec[(rd_base + i) % 256] == AW'(b*WORDS + i), "R4 address order",
                rec[(rd_base + i) % 256], b*WORDS + i);
        if (pass) begin
            for (int i = 0; i < WORDS; i++) exp_cfg[i] = mem[b*WORDS + i];
            chk(out_en && !csum_fail, "R5 R6 pass flags", {out_en, csum_fail}, 2);
            chk(we_count - we_base == WORDS, "R10 copy strobes", we_count - we_base, WORDS);
            cfg_all_match("R6 copied contents");
        end else begin
            chk(!out_en && csum_fail, "R5 R7 fail flags", {out_en, csum_fail}, 1);
            chk(we_count - we_base == 0, "R10 no strobes on fail", we_count - we_base, 0);
            cfg_all_match("R7 defaults kept");
        end
        chk(early_cnt == early_base, "R6 out_en not early", early_cnt - early_base, 0);
    endtask

    task automatic ser_case(input int a, input logic [7:0] d, input bit dis);
        int we_base;
        wire_dis = dis;
        we_base = we_count;
        ser_write(a, d);
        @(negedge clk);
        if (!dis) exp_cfg[a] = d;
        chk(we_count - we_base == (dis ? 0 : 1), "R8 R10 serial strobe", we_count - we_base, dis ? 0 : 1);
        cfg_all_match(dis ? "R8 blocked write" : "R8 accepted write");
        wire_dis = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NBANKS*WORDS; i++) mem[i] = 8'h00;
        for (int i = 0; i < WORDS; i++) exp_cfg[i] = RSTV;
        repeat (3) @(negedge clk);
        // R1 reset state
        #1;
        chk(!out_en && !load_done && !csum_fail && !mem_rd_en, "R1 reset flags", {out_en, load_done, csum_fail}, 0);
        cfg_all_match("R1 reset defaults");

        // R3 R6 valid bank, serial write during load ignored (R8)
        fill_bank(2, 1'b1);
        boot(2, 1'b1, 1'b1);
        ser_case(3, 8'hC3, 1'b0);
        ser_case(5, 8'h11, 1'b1);

        // R9 dip then R2 R7 delayed boot with bad bank
        fill_bank(1, 1'b0);
        boot(1, 1'b0, 1'b0);
        ser_case(6, 8'h77, 1'b0);

        // R5 all-zero bank passes
        for (int i = 0; i < WORDS; i++) mem[3*WORDS + i] = 8'h00;
        boot(3, 1'b1, 1'b0);

        // R2 R6 delayed boot with good bank
        fill_bank(0, 1'b1);
        boot(0, 1'b0, 1'b0);

        // random mix
        for (int it = 0; it < 6; it++) begin
            int b;
            b = $urandom_range(0, NBANKS-1);
            fill_bank(b, $urandom_range(0, 1) == 1);
            boot(b, 1'b1, $urandom_range(0, 1) == 1);
            if ($urandom_range(0, 1) == 1)
                ser_case($urandom_range(0, WORDS-1), 8'($urandom), $urandom_range(0, 1) == 1);
        end

        drop_supply();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule